// File: doc/BRIEF.md
# Local SRAM Window Decoder

This block decides, for every processor bus access, whether the access is served by a small on-chip SRAM. The SRAM covers a 4-Kbyte window, organised as 1024 words of 32 bits. A single 32-bit control register sets where the window sits, whether it may be written, and which address-space types may reach it. Each access carries an address, a read/write flag, four byte enables and a 3-bit address-space code. The block answers in the same cycle with a hit flag and an access-error pulse. For a read hit, the data follows one clock later.

The processor can only write the control register, and only through a control-register port that carries a 12-bit register code. A separate debug port can both write the register and read it back. The block also raises a configuration warning for one setting that software must avoid: the window based at address zero while CPU-space and interrupt-acknowledge cycles can still reach it.

Accesses that miss are left to the external memory path. The hit flag low tells that path to take the access.

Top module: `sram_window`

## Requirements
- R1: The debug port always reads the register image with this layout: window base in bits 31..12, write protect in bit 8, the five space-mask bits in bits 5..1, and valid in bit 0. Bits 11..9 and 7..6 read as 0 whatever was written to them.
- R2: After reset, valid reads 0. While valid is 0, no access gives `acc_hit` or `acc_err`.
- R3: An access hits when all of these hold: `acc_valid` is 1, valid is 1, address bits 31..12 equal the base, and the space is unmasked. Space codes are 0 = CPU/interrupt acknowledge, 1 = supervisor code, 2 = supervisor data, 3 = user code, 4 = user data. Codes 5..7 never hit.
- R4: The mask bit for space code s is register bit 5-s. While that bit is 1, accesses of that space give neither hit nor error, and their writes leave memory unchanged.
- R5: While write protect is 1, read hits still return data. A write hit raises `acc_err` in the same cycle and leaves memory unchanged.
- R6: A write hit that is not protected updates only the bytes whose enable bit is set. `acc_be[i]` selects data bits 8i+7..8i.
- R7: `rd_data` carries the addressed word one clock after a read hit, and it holds its value in every cycle without a read hit.
- R8: A CPU register write takes effect only when `cpu_reg_code` equals 0xC04. Writes with any other code leave the register unchanged.
- R9: When the CPU port and the debug port both write in the same cycle, the debug value is stored.
- R10: `cfg_warn` is 1 exactly when valid is 1, the base is 0 and the CPU-space mask (bit 5) is 0.
- R11: A cycle with `acc_valid` at 0 gives no hit and no error, and writes nothing to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_be | input | 4 | Byte enables for writes |
| acc_space | input | 3 | Address-space code |
| acc_wdata | input | 32 | Write data |
| acc_hit | output | 1 | Access is served by the SRAM (combinational) |
| acc_err | output | 1 | Write to a protected window (combinational) |
| rd_data | output | 32 | Read data, one clock after a read hit |
| cpu_reg_we | input | 1 | CPU control-register write strobe |
| cpu_reg_code | input | 12 | Control-register code of the CPU write |
| cpu_reg_wdata | input | 32 | CPU write value |
| dbg_we | input | 1 | Debug write strobe |
| dbg_wdata | input | 32 | Debug write value |
| dbg_rdata | output | 32 | Debug read-back of the register image |
| cfg_warn | output | 1 | Base 0 with CPU-space mask clear |

## Verification
The assertions assume that the address, space, write and byte-enable inputs are stable and known throughout any cycle in which `acc_valid` is 1. They also assume that reset is held for at least one clock edge before traffic starts. The bench drives every input at the falling edge and releases `acc_valid` and both write strobes one nanosecond after the next rising edge. As a result, each access and each register write occupies exactly one sampled cycle. The bench does not read the non-valid register fields or the memory words until it has written them, because they have no reset value.

// File: rtl/sram_window_pkg.sv
package sram_window_pkg;

   typedef enum logic [2:0] {
      SP_CPU_IACK = 3'd0,
      SP_SUP_CODE = 3'd1,
      SP_SUP_DATA = 3'd2,
      SP_USR_CODE = 3'd3,
      SP_USR_DATA = 3'd4
   } space_e;

   localparam int NUM_SPACES = 5;

   // register image bit positions that decode logic depends on
   localparam int WP_POS   = 8;
   localparam int MASK_LO  = 1;
   localparam int VALID_POS = 0;

   // position of the mask bit for a space inside the 5-bit mask vector
   function automatic int mask_slot(input int space);
      return NUM_SPACES - 1 - space;
   endfunction

endpackage

// File: rtl/sram_window_cfg.sv
module sram_window_cfg
   import sram_window_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WIN_BITS  = 12,
   parameter int CODE_W    = 12,
   parameter logic [CODE_W-1:0] CTRL_CODE = 12'hC04
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cpu_we,
   input  logic [CODE_W-1:0]        cpu_code,
   input  logic [ADDR_W-1:0]        cpu_wdata,
   input  logic                     dbg_we,
   input  logic [ADDR_W-1:0]        dbg_wdata,
   output logic [ADDR_W-1:0]        dbg_rdata,
   output logic [ADDR_W-WIN_BITS-1:0] base,
   output logic                     wp,
   output logic [NUM_SPACES-1:0]    mask,
   output logic                     valid,
   output logic                     warn
);
   localparam int BASE_W = ADDR_W - WIN_BITS;
   localparam logic [ADDR_W-1:0] KEEP =
      {{BASE_W{1'b1}}, {(WIN_BITS-WP_POS-1){1'b0}}, 1'b1,
       {(WP_POS-MASK_LO-NUM_SPACES){1'b0}}, {NUM_SPACES{1'b1}}, 1'b1};

   if (WIN_BITS <= WP_POS || WIN_BITS >= ADDR_W) begin : g_bad_win
      $error("sram_window_cfg: WIN_BITS out of range");
   end

   logic              wr_en;
   logic [ADDR_W-1:0] wr_val;

   assign wr_en  = dbg_we | (cpu_we & (cpu_code == CTRL_CODE));
   assign wr_val = dbg_we ? dbg_wdata : cpu_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid <= 1'b0;
      else if (wr_en) valid <= wr_val[VALID_POS];
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         base <= wr_val[ADDR_W-1:WIN_BITS];
         wp   <= wr_val[WP_POS];
         mask <= wr_val[MASK_LO +: NUM_SPACES];
      end
   end

   always_comb begin
      dbg_rdata = '0;
      dbg_rdata[ADDR_W-1:WIN_BITS]       = base;
      dbg_rdata[WP_POS]                  = wp;
      dbg_rdata[MASK_LO +: NUM_SPACES]   = mask;
      dbg_rdata[VALID_POS]               = valid;
   end

   assign warn = valid & (base == '0) & ~mask[mask_slot(0)];

   AST_DBG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_we |=> dbg_rdata == ($past(dbg_wdata) & KEEP)); // R9
   AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_code != CTRL_CODE && !dbg_we) |=> $stable(dbg_rdata)); // R8
endmodule

// File: rtl/sram_window_decode.sv
module sram_window_decode
   import sram_window_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIN_BITS = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       valid,
   input  logic [ADDR_W-WIN_BITS-1:0] base,
   input  logic                       wp,
   input  logic [NUM_SPACES-1:0]      mask,
   input  logic                       acc_valid,
   input  logic [ADDR_W-1:0]          acc_addr,
   input  logic                       acc_write,
   input  logic [2:0]                 acc_space,
   output logic                       hit,
   output logic                       err,
   output logic                       mem_we,
   output logic                       mem_re
);
   logic [NUM_SPACES-1:0] space_open;
   logic                  space_ok;
   logic                  in_win;

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
      assign space_open[s] = (acc_space == 3'(s)) & ~mask[mask_slot(s)];
   end

   assign space_ok = |space_open;
   assign in_win   = acc_addr[ADDR_W-1:WIN_BITS] == base;
   assign hit      = acc_valid & valid & in_win & space_ok;
   assign err      = hit & acc_write & wp;
   assign mem_we   = hit & acc_write & ~wp;
   assign mem_re   = hit & ~acc_write;

   AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> !hit && !err); // R2
endmodule

// File: rtl/sram_window_mem.sv
module sram_window_mem #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 10
) (
   input  logic                  clk,
   input  logic                  we,
   input  logic                  re,
   input  logic [IDX_W-1:0]      idx,
   input  logic [DATA_W/8-1:0]   be,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int DEPTH = 1 << IDX_W;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("sram_window_mem: DATA_W must be a multiple of 8");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] store [DEPTH];
      logic [7:0] lane_q;

      always_ff @(posedge clk) begin
         if (we && be[g]) store[idx] <= wdata[8*g +: 8];
         if (re)          lane_q     <= store[idx];
      end

      assign rdata[8*g +: 8] = lane_q;
   end
endmodule

// File: rtl/sram_window.sv
module sram_window
   import sram_window_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int WIN_BITS = 12,
   parameter int CODE_W   = 12,
   parameter logic [CODE_W-1:0] CTRL_CODE = 12'hC04
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic                acc_write,
   input  logic [DATA_W/8-1:0] acc_be,
   input  logic [2:0]          acc_space,
   input  logic [DATA_W-1:0]   acc_wdata,
   output logic                acc_hit,
   output logic                acc_err,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                cpu_reg_we,
   input  logic [CODE_W-1:0]   cpu_reg_code,
   input  logic [ADDR_W-1:0]   cpu_reg_wdata,
   input  logic                dbg_we,
   input  logic [ADDR_W-1:0]   dbg_wdata,
   output logic [ADDR_W-1:0]   dbg_rdata,
   output logic                cfg_warn
);
   localparam int BYTE_BITS = $clog2(DATA_W / 8);
   localparam int IDX_W     = WIN_BITS - BYTE_BITS;
   localparam int BASE_W    = ADDR_W - WIN_BITS;

   if (IDX_W < 1 || IDX_W > 14) begin : g_bad_depth
      $error("sram_window: window depth out of range");
   end

   logic [BASE_W-1:0]     cfg_base;
   logic                  cfg_wp;
   logic [NUM_SPACES-1:0] cfg_mask;
   logic                  cfg_valid;
   logic                  mem_we;
   logic                  mem_re;

   sram_window_cfg #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .CODE_W(CODE_W), .CTRL_CODE(CTRL_CODE)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(cpu_reg_we), .cpu_code(cpu_reg_code), .cpu_wdata(cpu_reg_wdata),
      .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
      .base(cfg_base), .wp(cfg_wp), .mask(cfg_mask), .valid(cfg_valid),
      .warn(cfg_warn)
   );

   sram_window_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .valid(cfg_valid), .base(cfg_base), .wp(cfg_wp), .mask(cfg_mask),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_space(acc_space),
      .hit(acc_hit), .err(acc_err), .mem_we(mem_we), .mem_re(mem_re)
   );

   sram_window_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
      .clk(clk), .we(mem_we), .re(mem_re),
      .idx(acc_addr[WIN_BITS-1:BYTE_BITS]), .be(acc_be),
      .wdata(acc_wdata), .rdata(rd_data)
   );

   AST_MASKED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit |-> (acc_space < 3'd5) && !cfg_mask[3'd4 - acc_space]); // R4
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_hit && !acc_write) |=> $stable(rd_data)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !acc_hit && !acc_err); // R11
endmodule

// File: tb/sram_window_tb.sv
module sram_window_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 0, acc_write = 0;
   logic [31:0] acc_addr = 0, acc_wdata = 0;
   logic [3:0]  acc_be = 0;
   logic [2:0]  acc_space = 0;
   logic        acc_hit, acc_err, cfg_warn;
   logic [31:0] rd_data, dbg_rdata;
   logic        cpu_reg_we = 0, dbg_we = 0;
   logic [11:0] cpu_reg_code = 0;
   logic [31:0] cpu_reg_wdata = 0, dbg_wdata = 0;

   always #5 clk = ~clk;

   sram_window u_dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_be(acc_be), .acc_space(acc_space), .acc_wdata(acc_wdata),
      .acc_hit(acc_hit), .acc_err(acc_err), .rd_data(rd_data),
      .cpu_reg_we(cpu_reg_we), .cpu_reg_code(cpu_reg_code), .cpu_reg_wdata(cpu_reg_wdata),
      .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
      .cfg_warn(cfg_warn)
   );

   int          total = 0, bad = 0;
   bit          done = 0;
   logic [31:0] model [1024];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic [31:0] mon_e;
   string       mon_t;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: one access cycle, checks same-cycle flags, queues read data
   task automatic acc(input bit v, input logic [31:0] a, input bit w, input logic [3:0] be,
                      input logic [2:0] sp, input logic [31:0] wd,
                      input bit eh, input bit ee, input string req);
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_write = w; acc_be = be;
      acc_space = sp; acc_wdata = wd;
      #1;
      chk(acc_hit == eh, {req, " hit"}, 32'(acc_hit), 32'(eh));
      chk(acc_err == ee, {req, " err"}, 32'(acc_err), 32'(ee));
      if (eh && !w) begin
         exp_q.push_back(model[a[11:2]]);
         tag_q.push_back({req, " rdata"});
      end
      if (eh && w && !ee)
         for (int i = 0; i < 4; i++)
            if (be[i]) model[a[11:2]][8*i +: 8] = wd[8*i +: 8];
      @(posedge clk);
      #1 acc_valid = 0; acc_write = 0;
   endtask

   task automatic reg_wr(input bit cw, input logic [11:0] code, input logic [31:0] cd,
                         input bit dw, input logic [31:0] dd);
      @(negedge clk);
      cpu_reg_we = cw; cpu_reg_code = code; cpu_reg_wdata = cd;
      dbg_we = dw; dbg_wdata = dd;
      @(posedge clk);
      #1 cpu_reg_we = 0; dbg_we = 0;
   endtask

   task automatic rd_reg(input logic [31:0] e, input string req);
      @(negedge clk);
      chk(dbg_rdata == e, req, dbg_rdata, e);
   endtask

   task automatic warn_is(input bit e, input string req);
      @(negedge clk);
      chk(cfg_warn == e, req, 32'(cfg_warn), 32'(e));
   endtask

   // monitor: compares read data one cycle after each expected read hit
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         mon_e = exp_q.pop_front();
         mon_t = tag_q.pop_front();
         chk(rd_data == mon_e, mon_t, rd_data, mon_e);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R2: reset state
      @(negedge clk);
      chk(dbg_rdata[0] == 1'b0, "R2 valid after reset", 32'(dbg_rdata[0]), 0);
      acc(1, 32'h0000_0010, 0, 4'hF, 3'd2, 0, 0, 0, "R2");
      acc(1, 32'h0000_0010, 1, 4'hF, 3'd2, 0, 0, 0, "R2");

      // R1: layout, reserved bits dropped
      reg_wr(0, 0, 0, 1, 32'h2000_0EC1);
      rd_reg(32'h2000_0001, "R1 readback");
      warn_is(0, "R10 nonzero base");

      // R3/R6/R7: write, read, byte lanes
      acc(1, 32'h2000_0010, 1, 4'hF, 3'd2, 32'hAABB_CCDD, 1, 0, "R3");
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd2, 0, 1, 0, "R7");
      acc(1, 32'h2000_0010, 1, 4'b0101, 3'd2, 32'h1122_3344, 1, 0, "R6");
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd2, 0, 1, 0, "R6");
      acc(1, 32'h2000_0FFC, 1, 4'hF, 3'd4, 32'hDEAD_BEEF, 1, 0, "R3");
      acc(1, 32'h2000_0FFC, 0, 4'hF, 3'd0, 0, 1, 0, "R3");
      acc(1, 32'h2000_1010, 0, 4'hF, 3'd2, 0, 0, 0, "R3 above window");
      acc(1, 32'h1FFF_F010, 0, 4'hF, 3'd2, 0, 0, 0, "R3 below window");
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd5, 0, 0, 0, "R3 space 5");
      acc(1, 32'h2000_0010, 1, 4'hF, 3'd7, 0, 0, 0, "R3 space 7");
      @(negedge clk);
      chk(rd_data == 32'hDEAD_BEEF, "R7 hold", rd_data, 32'hDEAD_BEEF);

      // R11: idle cycle writes nothing
      acc(0, 32'h2000_0010, 1, 4'hF, 3'd2, 32'h0, 0, 0, "R11");
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd2, 0, 1, 0, "R11");

      // R4: each space mask
      for (int s = 0; s < 5; s++) begin
         reg_wr(0, 0, 0, 1, 32'h2000_0001 | (32'h1 << (5 - s)));
         acc(1, 32'h2000_0010, 0, 4'hF, 3'(s), 0, 0, 0, "R4 masked read");
         acc(1, 32'h2000_0010, 1, 4'hF, 3'(s), 32'h0, 0, 0, "R4 masked write");
         acc(1, 32'h2000_0010, 0, 4'hF, 3'((s + 1) % 5), 0, 1, 0, "R4 other space");
      end
      reg_wr(0, 0, 0, 1, 32'h2000_0001);
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd2, 0, 1, 0, "R4 memory untouched");

      // R5: write protect
      reg_wr(0, 0, 0, 1, 32'h2000_0101);
      rd_reg(32'h2000_0101, "R1 wp bit");
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd2, 0, 1, 0, "R5 read");
      acc(1, 32'h2000_0010, 1, 4'hF, 3'd2, 32'h0, 1, 1, "R5 write");
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd2, 0, 1, 0, "R5 unchanged");

      // R8: CPU code
      reg_wr(1, 12'hC05, 32'h3000_0001, 0, 0);
      rd_reg(32'h2000_0101, "R8 wrong code");
      reg_wr(1, 12'hC04, 32'h3000_0001, 0, 0);
      rd_reg(32'h3000_0001, "R8 right code");
      acc(1, 32'h3000_0010, 0, 4'hF, 3'd1, 0, 1, 0, "R8 new base");

      // R9: debug wins
      reg_wr(1, 12'hC04, 32'h4000_0001, 1, 32'h5000_0001);
      rd_reg(32'h5000_0001, "R9");

      // R10: warning
      reg_wr(0, 0, 0, 1, 32'h0000_0001);
      warn_is(1, "R10 base zero unmasked");
      reg_wr(0, 0, 0, 1, 32'h0000_0021);
      warn_is(0, "R10 base zero masked");
      reg_wr(0, 0, 0, 1, 32'h0000_0000);
      warn_is(0, "R10 invalid");

      // R2: valid cleared disables hits
      reg_wr(0, 0, 0, 1, 32'h2000_0000);
      acc(1, 32'h2000_0010, 0, 4'hF, 3'd2, 0, 0, 0, "R2 invalid");

      repeat (3) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule